// File: doc/BRIEF.md
# Wiper tap switch controller

This block sits between the registers of a digitally controlled potentiometer and its 256-tap resistor ladder. When it receives an update strobe, it samples an 8-bit wiper code and a shutdown flag. It then drives one switch enable per ladder tap, plus two terminal-control enables. One enable disconnects the high end of the ladder. The other shorts the wiper to the low terminal. The update strobe comes from the rising edge of the serial chip select, so a new setting takes effect only when a serial transaction ends.

A move between two taps uses make-before-break. The new tap switch closes first. Both switches then stay closed for a fixed number of system clocks. Only after that window does the old switch open. In shutdown, every tap switch opens, the high end is disconnected and the wiper is tied to the low end. On leaving shutdown, the tap for the presented code closes in a single step and the ladder is reconnected. All outputs are registered and all sizes are parameters.

Top module: `wiper_switch_ctrl`

## Requirements
- R1: Bit i of `tap_en_o` belongs to wiper code i. Bit 0 is the tap nearest the low terminal and bit 255 is the tap nearest the high terminal.
- R2: During and after a synchronous reset, `tap_en_o` has only bit 128 set, and `hi_open_o` and `wiper_short_o` are 0.
- R3: A strobe that carries a code different from the current tap, with the shutdown flag at 0, works as follows. The old tap alone stays enabled in the cycle after the sampling edge. From the second edge on, both the old and the new tap are enabled.
- R4: The overlap lasts exactly OVERLAP_CYC clock cycles, with OVERLAP_CYC of at least 1. After it, only the new tap is enabled.
- R5: A strobe with the shutdown flag at 1 clears every tap enable from the second edge on. It also drives `hi_open_o` and `wiper_short_o` to 1.
- R6: After any strobe, the outputs reach their final value within MAX_SETTLE_CYC clock cycles. The default is 375 cycles, which is 1.5 µs at 250 MHz.
- R7: Outside an overlap window exactly one tap enable is set. In shutdown none is set.
- R8: A strobe with the shutdown flag at 0 while in shutdown has this effect from the second edge on: only the tap of the presented code is enabled, and both terminal enables return to 0. No other tap is enabled on the way.
- R9: A strobe with the shutdown flag at 0 that carries the current code changes no output.
- R10: A strobe that arrives during an overlap window is held. It is applied one cycle after the window ends. If several strobes arrive in one window, the last one wins.
- R11: Changes on `wiper_code_i` or `shutdown_i` without a strobe have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wiper_code_i | input | CODE_W | Wiper position code, sampled on strobe |
| shutdown_i | input | 1 | 1 requests shutdown, sampled on strobe |
| apply_stb_i | input | 1 | One-cycle update strobe from the chip-select rising edge |
| tap_en_o | output | 2**CODE_W | One switch enable per ladder tap |
| hi_open_o | output | 1 | 1 disconnects the ladder's high end |
| wiper_short_o | output | 1 | 1 shorts the wiper to the low terminal |

## Verification
A vector table drives the strobe with several kinds of setting:
- adjacent and end-to-end code moves, which show the overlap timing and the mapping at codes 00h and FFh;
- a repeat of the current code, which must produce no overlap;
- entering shutdown, and shutdown again with a new code;
- leaving shutdown, which must restore the tap without an overlap.

Directed tests cover these cases:
- input changes without a strobe, which must be ignored;
- strobes stacked inside one overlap window, which show that they are held and that the last one wins;
- a reset in the middle of an overlap, which must return the wiper to code 128.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_OVL  = 2'd1,
    PH_SHDN = 2'd2
  } phase_t;
endpackage

// File: rtl/wsc_cmd_latch.sv
module wsc_cmd_latch #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [CODE_W-1:0] code_in,
  input  logic              shdn_in,
  input  logic              busy,
  output logic              go,
  output logic [CODE_W-1:0] go_code,
  output logic              go_shdn,
  output logic              pend_valid
);
  logic [CODE_W-1:0] pend_code;
  logic              pend_shdn;

  // A fresh strobe outranks an older held command.
  always_comb begin
    go      = !busy && (stb || pend_valid);
    go_code = stb ? code_in : pend_code;
    go_shdn = stb ? shdn_in : pend_shdn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_code  <= '0;
      pend_shdn  <= 1'b0;
    end else if (stb && busy) begin
      pend_valid <= 1'b1;
      pend_code  <= code_in;
      pend_shdn  <= shdn_in;
    end else if (!busy) begin
      pend_valid <= 1'b0;
    end
  end

  // R10: a held command is consumed as soon as the window closes
  assert_pend_drain_R10: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && !busy && !stb) |=> !pend_valid);
endmodule

// File: rtl/wsc_sequencer.sv
module wsc_sequencer
  import wsc_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int OVERLAP_CYC = 4,
  parameter int RESET_CODE  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [CODE_W-1:0] go_code,
  input  logic              go_shdn,
  output phase_t            phase,
  output logic [CODE_W-1:0] cur_code,
  output logic [CODE_W-1:0] nxt_code
);
  localparam int CNT_W = (OVERLAP_CYC < 2) ? 1 : $clog2(OVERLAP_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERLAP_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_HOLD;
      cur_code <= CODE_W'(RESET_CODE);
      nxt_code <= CODE_W'(RESET_CODE);
      cnt      <= '0;
    end else begin
      unique case (phase)
        PH_HOLD: begin
          if (go) begin
            if (go_shdn) begin
              phase    <= PH_SHDN;
              cur_code <= go_code;
            end else if (go_code != cur_code) begin
              phase    <= PH_OVL;
              nxt_code <= go_code;
              cnt      <= '0;
            end
          end
        end
        PH_OVL: begin
          if (cnt == CNT_LAST) begin
            phase    <= PH_HOLD;
            cur_code <= nxt_code;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SHDN: begin
          if (go) begin
            cur_code <= go_code;
            if (!go_shdn) phase <= PH_HOLD;
          end
        end
        default: phase <= PH_HOLD;
      endcase
    end
  end

  // R4: window counter never passes its limit
  assert_overlap_window_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OVL) |-> (cnt <= CNT_LAST));
  // R4: the window closes onto the new code
  assert_overlap_retire_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OVL && cnt == CNT_LAST) |=> (phase == PH_HOLD && cur_code == $past(nxt_code)));
  // R11: nothing moves without a command
  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOLD && !go) |=> (phase == PH_HOLD && $stable(cur_code)));
endmodule

// File: rtl/wsc_tap_decode.sv
module wsc_tap_decode
  import wsc_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int NUM_TAPS   = 256,
  parameter int RESET_CODE = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  phase_t              phase,
  input  logic [CODE_W-1:0]   cur_code,
  input  logic [CODE_W-1:0]   nxt_code,
  output logic [NUM_TAPS-1:0] tap_en_o,
  output logic                hi_open_o,
  output logic                wiper_short_o
);
  logic                show_cur;
  logic                show_nxt;
  logic [NUM_TAPS-1:0] tap_d;

  assign show_cur = (phase != PH_SHDN);
  assign show_nxt = (phase == PH_OVL);

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tap_d[i] = (show_cur && cur_code == CODE_W'(i)) ||
                      (show_nxt && nxt_code == CODE_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_en_o             <= '0;
      tap_en_o[RESET_CODE] <= 1'b1;
      hi_open_o            <= 1'b0;
      wiper_short_o        <= 1'b0;
    end else begin
      tap_en_o      <= tap_d;
      hi_open_o     <= (phase == PH_SHDN);
      wiper_short_o <= (phase == PH_SHDN);
    end
  end

  // R5: ladder fully open and wiper tied low together
  assert_shdn_open_R5: assert property (@(posedge clk) disable iff (rst)
    hi_open_o |-> (tap_en_o == '0 && wiper_short_o));
  // R7: one or two taps whenever the ladder is connected
  assert_tap_count_R7: assert property (@(posedge clk) disable iff (rst)
    !hi_open_o |-> ($countones(tap_en_o) == 1 || $countones(tap_en_o) == 2));
  // R3: a lone tap never hands over directly to another lone tap
  assert_make_first_R3: assert property (@(posedge clk) disable iff (rst)
    (!hi_open_o && !$past(hi_open_o) && $countones(tap_en_o) == 1 &&
     $countones($past(tap_en_o)) == 1) |-> (tap_en_o == $past(tap_en_o)));
  // R8: recovery lands on a single tap
  assert_restore_single_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(hi_open_o) && !hi_open_o) |-> ($countones(tap_en_o) == 1));
endmodule

// File: rtl/wiper_switch_ctrl.sv
module wiper_switch_ctrl
  import wsc_pkg::*;
#(
  parameter int CODE_W         = 8,
  parameter int OVERLAP_CYC    = 4,
  parameter int RESET_CODE     = 128,
  parameter int MAX_SETTLE_CYC = 375
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CODE_W-1:0]        wiper_code_i,
  input  logic                     shutdown_i,
  input  logic                     apply_stb_i,
  output logic [(1<<CODE_W)-1:0]   tap_en_o,
  output logic                     hi_open_o,
  output logic                     wiper_short_o
);
  localparam int NUM_TAPS = 1 << CODE_W;
  localparam int SET_W    = $clog2(MAX_SETTLE_CYC + 1);

  phase_t            phase;
  logic [CODE_W-1:0] cur_code;
  logic [CODE_W-1:0] nxt_code;
  logic              go;
  logic [CODE_W-1:0] go_code;
  logic              go_shdn;
  logic              pend_valid;
  logic              busy;

  assign busy = (phase == PH_OVL);

  wsc_cmd_latch #(.CODE_W(CODE_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .stb        (apply_stb_i),
    .code_in    (wiper_code_i),
    .shdn_in    (shutdown_i),
    .busy       (busy),
    .go         (go),
    .go_code    (go_code),
    .go_shdn    (go_shdn),
    .pend_valid (pend_valid)
  );

  wsc_sequencer #(
    .CODE_W      (CODE_W),
    .OVERLAP_CYC (OVERLAP_CYC),
    .RESET_CODE  (RESET_CODE)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .go_code  (go_code),
    .go_shdn  (go_shdn),
    .phase    (phase),
    .cur_code (cur_code),
    .nxt_code (nxt_code)
  );

  wsc_tap_decode #(
    .CODE_W     (CODE_W),
    .NUM_TAPS   (NUM_TAPS),
    .RESET_CODE (RESET_CODE)
  ) u_dec (
    .clk           (clk),
    .rst           (rst),
    .phase         (phase),
    .cur_code      (cur_code),
    .nxt_code      (nxt_code),
    .tap_en_o      (tap_en_o),
    .hi_open_o     (hi_open_o),
    .wiper_short_o (wiper_short_o)
  );

  // Settle watch: cycles since the latest strobe while work is outstanding.
  logic [SET_W-1:0] settle_cnt;
  always_ff @(posedge clk) begin
    if (rst || apply_stb_i) begin
      settle_cnt <= '0;
    end else if ((busy || pend_valid) && settle_cnt != SET_W'(MAX_SETTLE_CYC)) begin
      settle_cnt <= settle_cnt + 1'b1;
    end
  end

  // R6: outstanding work clears early enough to leave room for the output register
  assert_settle_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (busy || pend_valid) |-> (settle_cnt < SET_W'(MAX_SETTLE_CYC - 2)));
endmodule

// File: tb/wiper_switch_ctrl_tb_top.sv
module wiper_switch_ctrl_tb_top;
  localparam int OVL   = 4;
  localparam int MAXST = 375;
  localparam int NVEC  = 11;
  // {shutdown flag, code}
  localparam logic [8:0] VEC [0:NVEC-1] = '{
    {1'b0, 8'h81}, {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b0, 8'hFF},
    {1'b1, 8'hFF}, {1'b1, 8'h20}, {1'b0, 8'h20}, {1'b0, 8'h1F},
    {1'b1, 8'h1F}, {1'b0, 8'h1F}, {1'b0, 8'h7F}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   code_i = 8'h00;
  logic         shdn_i = 1'b0;
  logic         stb_i  = 1'b0;
  logic [255:0] tap_en;
  logic         hi_open;
  logic         w_short;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  wiper_switch_ctrl #(
    .CODE_W(8), .OVERLAP_CYC(OVL), .RESET_CODE(128), .MAX_SETTLE_CYC(MAXST)
  ) dut_i (
    .clk(clk), .rst(rst), .wiper_code_i(code_i), .shutdown_i(shdn_i),
    .apply_stb_i(stb_i), .tap_en_o(tap_en), .hi_open_o(hi_open),
    .wiper_short_o(w_short)
  );

  function automatic logic [255:0] oh(input logic [7:0] c);
    logic [255:0] r;
    r = '0;
    r[c] = 1'b1;
    return r;
  endfunction

  task automatic check(input logic [255:0] exp_tap, input logic exp_sd, input string tag);
    checks++;
    if (tap_en !== exp_tap || hi_open !== exp_sd || w_short !== exp_sd) begin
      failures++;
      $display("FAIL %s: tap=%h hi=%b sh=%b expected tap=%h hi=%b sh=%b",
               tag, tap_en, hi_open, w_short, exp_tap, exp_sd, exp_sd);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a falling edge; strobe is sampled at the next rising edge.
  task automatic do_strobe(input logic [7:0] c, input logic s);
    code_i = c;
    shdn_i = s;
    stb_i  = 1'b1;
    @(negedge clk);
    stb_i  = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] m_code;
    logic       m_shdn;
    logic [7:0] c;
    logic       s;
    logic [255:0] old_tap;

    cyc(3);
    check(oh(8'd128), 1'b0, "R2 reset held");
    rst = 1'b0;
    cyc(1);
    check(oh(8'd128), 1'b0, "R2 after reset release");
    m_code = 8'd128;
    m_shdn = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      s = VEC[v][8];
      c = VEC[v][7:0];
      old_tap = m_shdn ? '0 : oh(m_code);
      do_strobe(c, s);
      check(old_tap, m_shdn, "R3 prior state in first cycle");
      if (s) begin
        cyc(1);
        check('0, 1'b1, "R5 shutdown applied");
        m_code = c;
        m_shdn = 1'b1;
      end else if (m_shdn) begin
        cyc(1);
        check(oh(c), 1'b0, "R8 restore in one step");
        m_code = c;
        m_shdn = 1'b0;
      end else if (c == m_code) begin
        cyc(1);
        check(oh(c), 1'b0, "R9 same code no change");
      end else begin
        cyc(1);
        check(oh(m_code) | oh(c), 1'b0, "R3 both taps closed");
        cyc(OVL - 1);
        check(oh(m_code) | oh(c), 1'b0, "R4 overlap last cycle");
        cyc(1);
        check(oh(c), 1'b0, "R4 R1 R6 new tap only");
        m_code = c;
      end
      cyc(OVL + 2);
      check(m_shdn ? '0 : oh(m_code), m_shdn, "R7 settled state");
    end

    // R11: inputs move without a strobe
    code_i = 8'h05;
    shdn_i = 1'b1;
    cyc(10);
    check(oh(8'h7F), 1'b0, "R11 no strobe no effect");

    // R10: strobes stacked inside one window, last wins
    do_strobe(8'h10, 1'b0);
    do_strobe(8'h11, 1'b0);
    do_strobe(8'h12, 1'b0);
    cyc(OVL - 2);
    check(oh(8'h7F) | oh(8'h10), 1'b0, "R10 first window still open");
    cyc(1);
    check(oh(8'h10), 1'b0, "R10 gap between windows");
    cyc(1);
    check(oh(8'h10) | oh(8'h12), 1'b0, "R10 held command overlap");
    cyc(OVL - 1);
    check(oh(8'h10) | oh(8'h12), 1'b0, "R10 held overlap last cycle");
    cyc(1);
    check(oh(8'h12), 1'b0, "R10 last strobe wins");

    // R2: reset in the middle of an overlap
    do_strobe(8'h40, 1'b0);
    cyc(1);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    check(oh(8'd128), 1'b0, "R2 reset during overlap");
    cyc(OVL + 2);
    check(oh(8'd128), 1'b0, "R2 R7 stays at reset tap");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule